// File: doc/BRIEF.md
# BCD Digit Subtractor with Borrow

This block takes one decimal digit away from another. Both digits are in 8421 BCD. A borrow bit arriving from the next less significant digit position is also taken away. The block is purely combinational. It returns one BCD difference digit and a borrow bit. The borrow bit goes out to the next more significant digit position, so a row of these blocks, or one block used once per digit, forms a multi-digit decimal subtractor.

Inside, the block has two stages. The first stage runs a plain 4-bit binary subtraction with borrow. When that subtraction borrows, the result is a binary wrap-around value. The second stage corrects it by taking away six more, which turns it into the ten's-complement decimal digit. When the first stage does not borrow, its result passes through unchanged.

Top module: `bcd_digit_sub`

## Requirements
- R1: Both input digits use 4-bit 8421 encoding with values 0 to 9. The borrow-in is a single bit whose value is 0 or 1. The combined result r = minuend − subtrahend − borrow-in lies in −10..+9.
- R2: The first stage forms minuend − subtrahend − borrow-in in 4-bit binary, giving a borrow flag and a 4-bit value. The borrow flag weighs −16.
- R3: `borrow_o` is 1 exactly when r is negative, and it equals the borrow flag of the first stage.
- R4: When r is 0 to 9, `digit_o` equals r.
- R5: When r is −1 to −10, `digit_o` equals r + 10. So −1 gives 1001 and −10 gives 0000, each with `borrow_o` = 1.
- R6: For every valid input combination, `digit_o` is a legal BCD digit (0 to 9).
- R7: Feeding `borrow_o` of a lower digit into `borrow_i` of the next higher digit gives the correct multi-digit decimal difference, modulo 10^n, with a final borrow when the minuend is smaller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend_i | input | 4 | BCD digit being subtracted from |
| subtrahend_i | input | 4 | BCD digit being subtracted |
| borrow_i | input | 1 | Borrow from the less significant digit |
| digit_o | output | 4 | BCD difference digit |
| borrow_o | output | 1 | Borrow to the more significant digit |

## Verification
The assertions only check anything when both input digits are at most nine. Codes 1010 to 1111 produce outputs that are left unspecified. The stimulus never drives those codes: the bench walks all 200 legal combinations exhaustively, and its random draws take each digit modulo ten. Multi-digit chains are built the same way, with the borrow of each digit carried into the next.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
    parameter int DIG_W = 4;
    parameter int RADIX = 10;
    localparam int CORR = (1 << DIG_W) - RADIX;

    typedef struct packed {
        logic             brw;
        logic [DIG_W-1:0] val;
    } stage_t;
endpackage

// File: rtl/bin_sub_stage.sv
module bin_sub_stage
    import bcd_sub_pkg::*;
(
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    input  logic             bin_i,
    output stage_t           res_o
);
    stage_t res_d;

    always_comb begin
        res_d = {{1'b0, a_i} - {1'b0, b_i} - {{DIG_W{1'b0}}, bin_i}};
    end

    assign res_o = res_d;

    // R2: the flag-weighted value equals the signed difference
    always_comb begin
        if (int'(a_i) < RADIX && int'(b_i) < RADIX) begin
            a_r2_weighted_value: assert (int'(res_o.val) - (res_o.brw ? (1 << DIG_W) : 0)
                                         == int'(a_i) - int'(b_i) - int'(bin_i));
        end
    end
endmodule

// File: rtl/bcd_fix_stage.sv
module bcd_fix_stage
    import bcd_sub_pkg::*;
(
    input  stage_t           raw_i,
    output logic [DIG_W-1:0] digit_o
);
    localparam logic [DIG_W-1:0] CORR_V = DIG_W'(CORR);

    logic [DIG_W-1:0] digit_d;

    always_comb begin
        digit_d = raw_i.val - (raw_i.brw ? CORR_V : '0);
    end

    assign digit_o = digit_d;

    // R4: no borrow means the value passes untouched
    always_comb begin
        if (!raw_i.brw) begin
            a_r4_pass_through: assert (digit_o == raw_i.val);
        end
    end
endmodule

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub
    import bcd_sub_pkg::*;
(
    input  logic [3:0] minuend_i,
    input  logic [3:0] subtrahend_i,
    input  logic       borrow_i,
    output logic [3:0] digit_o,
    output logic       borrow_o
);
    stage_t raw_d;

    bin_sub_stage u_bin (
        .a_i   (minuend_i),
        .b_i   (subtrahend_i),
        .bin_i (borrow_i),
        .res_o (raw_d)
    );

    bcd_fix_stage u_fix (
        .raw_i   (raw_d),
        .digit_o (digit_o)
    );

    assign borrow_o = raw_d.brw;

    always_comb begin
        if (int'(minuend_i) < RADIX && int'(subtrahend_i) < RADIX) begin
            // R6: legal digit out
            a_r6_digit_legal: assert (int'(digit_o) < RADIX);
            // R3: borrow exactly when the result is negative
            a_r3_borrow_sign: assert (borrow_o == (int'(minuend_i) < int'(subtrahend_i) + int'(borrow_i)));
            // R5: negative results come out as r + 10
            if (borrow_o) begin
                a_r5_tens_compl: assert (int'(digit_o) == int'(minuend_i) + RADIX
                                         - int'(subtrahend_i) - int'(borrow_i));
            end
        end
    end
endmodule

// File: tb/sim_bcd_digit_sub.sv
module sim_bcd_digit_sub;
    logic clk = 1'b0;
    logic [3:0] x, y, d;
    logic bi, bo;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_digit_sub u0 (
        .minuend_i    (x),
        .subtrahend_i (y),
        .borrow_i     (bi),
        .digit_o      (d),
        .borrow_o     (bo)
    );

    function automatic int exp_digit(int a, int b, int c);
        int r = a - b - c;
        return (r < 0) ? r + 10 : r;
    endfunction

    function automatic bit exp_borrow(int a, int b, int c);
        return (a - b - c) < 0;
    endfunction

    task automatic apply(input int a, input int b, input int c, input string req);
        @(posedge clk);
        x = 4'(a); y = 4'(b); bi = c[0];
        @(negedge clk);
        checks++;
        if (int'(d) != exp_digit(a, b, c) || bo != exp_borrow(a, b, c)) begin
            errors++;
            $display("FAIL %s: %0d-%0d-%0d got digit=%0d borrow=%0d exp digit=%0d borrow=%0d",
                     req, a, b, c, d, bo, exp_digit(a, b, c), exp_borrow(a, b, c));
        end
    endtask

    task automatic chain(input int n_digits);
        int ma = 0, sb = 0, got = 0, pw = 1, brw = 0, mod = 1;
        for (int k = 0; k < n_digits; k++) begin
            int da = int'($urandom % 10);
            int db = int'($urandom % 10);
            ma += da * pw; sb += db * pw;
            @(posedge clk);
            x = 4'(da); y = 4'(db); bi = brw[0];
            @(negedge clk);
            got += int'(d) * pw;
            brw = int'(bo);
            pw *= 10;
        end
        mod = pw;
        checks++;
        if (got != (((ma - sb) % mod) + mod) % mod || brw != int'(ma < sb)) begin
            errors++;
            $display("FAIL R7: %0d-%0d got %0d borrow=%0d exp %0d borrow=%0d",
                     ma, sb, got, brw, (((ma - sb) % mod) + mod) % mod, ma < sb);
        end
    endtask

    initial begin
        x = '0; y = '0; bi = 1'b0;
        void'($urandom(32'd2024));
        // R1 resting point: 0-0-0
        apply(0, 0, 0, "R1");
        // R5 corner cases: -1 and -10
        apply(0, 0, 1, "R5");
        apply(0, 9, 1, "R5");
        apply(9, 0, 0, "R4");
        apply(9, 9, 1, "R5");
        // R2 R3 R4 R5 R6: all 200 legal combinations
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 2; c++)
                    apply(a, b, c, (a - b - c) < 0 ? "R3/R5" : "R2/R4");
        // R6 random legal digits
        for (int i = 0; i < 100; i++)
            apply(int'($urandom % 10), int'($urandom % 10), int'($urandom % 2), "R6");
        // R7 multi-digit chains
        for (int i = 0; i < 40; i++)
            chain(1 + i % 6);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule